// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer by another. It produces one quotient bit per clock, so a division takes one cycle per bit of the word. The caller presents a dividend, a divisor and a mode bit together with a one-cycle start pulse while the block is idle. The block raises busy while it works. When the division completes, it pulses done for one cycle. The quotient and remainder outputs then stay valid until the next accepted start.

The datapath holds three registers:
- a partial remainder that is one bit wider than the word, so that the sign of a trial difference is visible;
- a quotient register, which starts out holding the dividend;
- a divisor register, which is also one bit wider than the word.

Each iteration shifts the remainder and quotient left together as one register. It then subtracts the divisor from the new remainder. If the difference is negative, the unsubtracted value is kept and the new quotient bit is 0. Otherwise the difference is kept and the quotient bit is 1. Keeping the unsubtracted value does the restore step in the same cycle as the subtraction.

In signed mode the block divides magnitudes and then corrects the signs. A zero divisor is not iterated. The block reports it through a flag instead.

Top module: `restoring_divider`

## Requirements
- R1: After reset, busy_o, done_o and div_zero_o are all 0.
- R2: With the block idle, a start with a nonzero divisor raises busy_o on the following cycle. busy_o then stays high until the result is delivered.
- R3: For a nonzero divisor, done_o is high for exactly one cycle. It rises on the (WIDTH+1)th rising edge, counting the edge that samples start, and busy_o is low in that cycle.
- R4: In unsigned mode (signed_i = 0), quotient_o is the floor of dividend/divisor. remainder_o is dividend − quotient·divisor.
- R5: While busy, the internal partial remainder stays strictly below the divisor magnitude.
- R6: In signed mode (signed_i = 1, operands in two's complement), the quotient is truncated toward zero. It is negative exactly when the operand signs differ.
- R7: In signed mode, the remainder takes the dividend's sign, and its magnitude is below the divisor's magnitude.
- R8: In signed mode, the most negative dividend divided by −1 returns the low WIDTH bits of the true quotient, which is the most negative value. The remainder is 0.
- R9: A zero divisor, in either mode, gives done_o one rising edge after start with div_zero_o = 1. quotient_o is then all ones and remainder_o is the raw dividend.
- R10: A start pulse while busy_o is high is ignored. It neither changes the result in progress nor produces an extra done_o.
- R11: quotient_o, remainder_o and div_zero_o hold their values after done_o until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| signed_i | input | 1 | 1: operands are two's complement; 0: unsigned |
| dividend_i | input | WIDTH | Dividend |
| divisor_i | input | WIDTH | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Result came from a zero divisor |
| quotient_o | output | WIDTH | Quotient |
| remainder_o | output | WIDTH | Remainder |

## Verification
The bench targets several edges of the arithmetic:
- Unsigned operands with the top bit set. A divider that treated them as signed would return wrong quotients for these.
- Each of the four sign combinations in signed mode. A sign-fix error would flip the quotient, or give the remainder the divisor's sign.
- The most negative value divided by −1, which wrecks a divider that saturates or traps.
- Zero divisors in both modes. These catch a block that iterates anyway or returns an unsigned-corrected remainder.

A start pulse is also injected mid-division. A block that reloads on it would return the wrong operands' result or an extra done. Latency is counted for every result, so an off-by-one iteration count shows up as both a timing failure and a shifted quotient.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rdiv_state_e;
endpackage

// File: rtl/rdiv_operand_prep.sv
// Turns raw operands into magnitudes plus sign flags for signed mode.
module rdiv_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic             signed_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] mag_dividend_o,
  output logic [WIDTH-1:0] mag_divisor_o,
  output logic             neg_dividend_o,
  output logic             neg_divisor_o
);
  always_comb begin
    neg_dividend_o = signed_i & dividend_i[WIDTH-1];
    neg_divisor_o  = signed_i & divisor_i[WIDTH-1];
    mag_dividend_o = neg_dividend_o ? (~dividend_i + 1'b1) : dividend_i;
    mag_divisor_o  = neg_divisor_o  ? (~divisor_i  + 1'b1) : divisor_i;
  end
endmodule

// File: rtl/rdiv_restore_step.sv
// One restoring iteration: shift, trial subtract, keep or restore.
module rdiv_restore_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH:0]   rem_i,
  input  logic [WIDTH-1:0] quo_i,
  input  logic [WIDTH:0]   dvs_i,
  output logic [WIDTH:0]   rem_o,
  output logic [WIDTH-1:0] quo_o
);
  logic [WIDTH:0] shifted;
  logic [WIDTH:0] trial;

  always_comb begin
    shifted = {rem_i[WIDTH-1:0], quo_i[WIDTH-1]};
    trial   = shifted - dvs_i;
    if (trial[WIDTH]) begin
      rem_o = shifted;
      quo_o = {quo_i[WIDTH-2:0], 1'b0};
    end else begin
      rem_o = trial;
      quo_o = {quo_i[WIDTH-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/rdiv_result_fix.sv
// Applies the recorded signs to the unsigned quotient and remainder.
module rdiv_result_fix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] quo_i,
  input  logic [WIDTH-1:0] rem_i,
  input  logic             quo_neg_i,
  input  logic             rem_neg_i,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);
  always_comb begin
    quo_o = quo_neg_i ? (~quo_i + 1'b1) : quo_i;
    rem_o = rem_neg_i ? (~rem_i + 1'b1) : rem_i;
  end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             signed_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             div_zero_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o
);
  import rdiv_pkg::*;

  localparam int CW = $clog2(WIDTH + 1);

  rdiv_state_e    state_q, state_d;
  logic [WIDTH:0]   rem_q, rem_d, rem_step;
  logic [WIDTH-1:0] quo_q, quo_d, quo_step;
  logic [WIDTH:0]   dvs_q, dvs_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             dz_q, dz_d;
  logic             qneg_q, qneg_d, rneg_q, rneg_d;
  logic             dp_en;

  logic [WIDTH-1:0] mag_a, mag_b;
  logic             neg_a, neg_b;

  rdiv_operand_prep #(.WIDTH(WIDTH)) prep_i (
    .signed_i       (signed_i),
    .dividend_i     (dividend_i),
    .divisor_i      (divisor_i),
    .mag_dividend_o (mag_a),
    .mag_divisor_o  (mag_b),
    .neg_dividend_o (neg_a),
    .neg_divisor_o  (neg_b)
  );

  rdiv_restore_step #(.WIDTH(WIDTH)) step_i (
    .rem_i (rem_q),
    .quo_i (quo_q),
    .dvs_i (dvs_q),
    .rem_o (rem_step),
    .quo_o (quo_step)
  );

  rdiv_result_fix #(.WIDTH(WIDTH)) fix_i (
    .quo_i     (quo_q),
    .rem_i     (rem_q[WIDTH-1:0]),
    .quo_neg_i (qneg_q),
    .rem_neg_i (rneg_q),
    .quo_o     (quotient_o),
    .rem_o     (remainder_o)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    cnt_d   = cnt_q;
    dz_d    = dz_q;
    qneg_d  = qneg_q;
    rneg_d  = rneg_q;
    done_d  = 1'b0;
    dp_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          dp_en = 1'b1;
          if (divisor_i == '0) begin
            done_d = 1'b1;
            dz_d   = 1'b1;
            quo_d  = '1;
            rem_d  = {1'b0, dividend_i};
            qneg_d = 1'b0;
            rneg_d = 1'b0;
          end else begin
            state_d = ST_RUN;
            dz_d    = 1'b0;
            rem_d   = '0;
            quo_d   = mag_a;
            dvs_d   = {1'b0, mag_b};
            cnt_d   = CW'(WIDTH);
            qneg_d  = neg_a ^ neg_b;
            rneg_d  = neg_a;
          end
        end
      end
      ST_RUN: begin
        dp_en = 1'b1;
        rem_d = rem_step;
        quo_d = quo_step;
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      dz_q    <= dz_d;
      cnt_q   <= cnt_d;
    end
  end

  // Datapath registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (dp_en) begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      qneg_q <= qneg_d;
      rneg_q <= rneg_d;
    end
  end

  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = done_q;
  assign div_zero_o = dz_q;

  // Assertions
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> !done_o);
  p_busy_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o && !div_zero_o);
  p_rem_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> rem_q < dvs_q);
  p_dz_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && div_zero_o |-> quotient_o == '1);
  p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(dvs_q));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i && !done_o |=> $stable(quotient_o) && $stable(remainder_o));
endmodule

// File: tb/restoring_divider_tb_top.sv
module restoring_divider_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, signed_i;
  logic [W-1:0] dividend_i, divisor_i;
  logic busy_o, done_o, div_zero_o;
  logic [W-1:0] quotient_o, remainder_o;

  restoring_divider #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .div_zero_o(div_zero_o),
    .quotient_o(quotient_o), .remainder_o(remainder_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         dz;
    int           scyc;
    string        tag;
  } exp_t;

  exp_t   sb[$];
  int     checks = 0;
  int     errors = 0;
  int     cyc = 0;
  logic [W-1:0] last_q, last_r;
  logic   last_dz;
  bit     finished = 0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      report();
    end
  end

  // Monitor: pops expected items when done_o pulses
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        chk(0, "R10 spurious done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(quotient_o == e.q, {e.tag, " quotient"}, quotient_o, e.q);
        chk(remainder_o == e.r, {e.tag, " remainder"}, remainder_o, e.r);
        chk(div_zero_o == e.dz, {e.tag, " div_zero (R9)"}, W'(div_zero_o), W'(e.dz));
        chk((cyc - e.scyc) == (e.dz ? 1 : W + 1), {e.tag, " latency (R3/R9)"},
            W'(cyc - e.scyc), W'(e.dz ? 1 : W + 1));
        chk(!busy_o, {e.tag, " busy low at done (R3)"}, W'(busy_o), 0);
        last_q = e.q; last_r = e.r; last_dz = e.dz;
      end
    end
  end

  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b, input bit sgn,
                                output logic [W-1:0] q, output logic [W-1:0] r);
    longint x, y, qq, rr;
    if (sgn) begin
      x = longint'($signed(a));
      y = longint'($signed(b));
    end else begin
      x = longint'({32'b0, a});
      y = longint'({32'b0, b});
    end
    qq = x / y;
    rr = x % y;
    q = qq[W-1:0];
    r = rr[W-1:0];
  endfunction

  task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit sgn,
                       input string tag, input bit intrude);
    exp_t e;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    if (b == '0) begin
      e.q = '1; e.r = a; e.dz = 1'b1;
    end else begin
      model(a, b, sgn, e.q, e.r); e.dz = 1'b0;
    end
    e.scyc = cyc; e.tag = tag;
    sb.push_back(e);
    dividend_i = a; divisor_i = b; signed_i = sgn; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (b != '0) chk(busy_o, {tag, " busy after start (R2)"}, W'(busy_o), 1);
    if (intrude) begin
      repeat (5) @(negedge clk);
      dividend_i = 32'h1234_5678; divisor_i = 32'h0000_0003; signed_i = ~sgn; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o, {tag, " still busy after ignored start (R10)"}, W'(busy_o), 1);
    end
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] lf;
    rst_n = 1'b0; start_i = 1'b0; signed_i = 1'b0; dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !div_zero_o, "R1 reset outputs", {busy_o, done_o, div_zero_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_op(32'd6, 32'd4, 0, "R4 6/4", 0);
    do_op(32'd8, 32'd3, 0, "R4 8/3", 0);
    do_op(32'd5, 32'd9, 0, "R4 small/large", 0);
    do_op(32'hFFFF_FFFF, 32'd1, 0, "R4 max/1", 0);
    do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R4 max/max", 0);
    do_op(32'h8000_0000, 32'd3, 0, "R4 topbit unsigned", 0);
    do_op(32'hFFFF_FFF9, 32'hFFFF_FFFE, 0, "R4 big/big unsigned", 0);
    do_op(32'hFFFF_FFF9, 32'd2, 1, "R6 R7 -7/2", 0);
    do_op(32'd7, 32'hFFFF_FFFE, 1, "R6 R7 7/-2", 0);
    do_op(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1, "R6 R7 -7/-2", 0);
    do_op(32'hFFFF_FFFA, 32'd3, 1, "R6 -6/3", 0);
    do_op(32'h8000_0000, 32'hFFFF_FFFF, 1, "R8 minneg/-1", 0);
    do_op(32'd1234, 32'd0, 0, "R9 unsigned by zero", 0);
    do_op(32'hFFFF_FFFB, 32'd0, 1, "R9 signed by zero", 0);
    do_op(32'd1000, 32'd7, 0, "R10 intruded 1000/7", 1);

    repeat (4) @(negedge clk);
    chk(quotient_o == last_q, "R11 quotient held", quotient_o, last_q);
    chk(remainder_o == last_r, "R11 remainder held", remainder_o, last_r);
    chk(div_zero_o == last_dz, "R11 flag held", W'(div_zero_o), W'(last_dz));

    lf = 32'hACE1_2468;
    for (int i = 0; i < 12; i++) begin
      logic [W-1:0] a, b;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      b = (i % 3 == 0) ? (lf >> (i + 8)) : lf;
      do_op(a, b, i[0], i[0] ? "R6 R7 sweep" : "R4 sweep", 0);
    end

    repeat (3) @(negedge clk);
    report();
  end
endmodule